// File: doc/BRIEF.md
# I2C Start Generator with Stuck-Bus Recovery

This block is the front end of an I2C master. It produces the START condition that opens every transfer. Before it does so, it makes sure the bus can carry one. A target that lost power or was reset halfway through a byte can be left holding SDA low. While that lasts, no START can be formed. On each request the block releases both lines and samples SDA at the end of an SCL-high phase. If SDA reads high, it forms the START at once. If SDA reads low, it clocks SCL with SDA released, at most nine times, until the target lets go. It then sends a STOP so the target's state machine resets, and only then sends the START.

Both lines are driven open-drain: an output of 1 pulls the wire low and an output of 0 releases it. Whenever the block lets SCL go, it checks that SCL really reads high. A wire held low by something else ends the sequence with a fault. The sequence also ends with a fault when SDA stays low after the ninth recovery pulse. A successful run ends with a one-cycle `done`, and the bus is left with SCL and SDA both pulled low, ready for the first data bit. A separate `recovered` flag reports that recovery pulses were needed. Every phase lasts `HALF_CNT` clock cycles, and the line inputs pass through two-flop synchronizers before they are used.

Top module: `i2c_start_recover`

## Requirements
- R1: After reset both pull-low enables (`scl_oe`, `sda_oe`) are 0, and `done`, `fault` and `recovered` are 0.
- R2: If SDA reads high at the first sample after a request, the START follows with no SCL pulse generated while SDA is released, and `recovered` stays 0.
- R3: If SDA reads low at that sample, the block pulls SCL low and releases it again, with SDA released, once per sample that still reads low. It stops as soon as a sample reads SDA high, and never issues more than 9 such pulses.
- R4: If SDA still reads low at the sample after the 9th recovery pulse, `fault` goes to 1, both enables return to 0, no START is formed and `done` is not pulsed.
- R5: If SCL reads low at the end of a phase in which the block has released it, `fault` goes to 1, both enables return to 0, and `done` is not pulsed.
- R6: `sda_oe` never changes in the same cycle in which `scl_oe` goes from 0 to 1. SDA moves only while the block holds SCL low, or as a START or STOP edge.
- R7: After one or more recovery pulses, the block forms a STOP (SDA rises while SCL is high) before the START. No STOP is formed when no recovery was needed.
- R8: A START is SDA falling while SCL is high, followed by `scl_oe` rising exactly `HALF_CNT` clock cycles later. Then `done` is high for exactly one cycle with `scl_oe`=1 and `sda_oe`=1.
- R9: `recovered` is 1 after a sequence that used at least one recovery pulse. `recovered` and `fault` both return to 0 on the next accepted request.
- R10: A `start_req` that arrives while a sequence is in progress is ignored: exactly one START and one `done` result.
- R11: SDA held low by another device together with the block is not a fault in itself: the block recovers when SDA is released within 9 pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to begin a START sequence |
| scl_in | input | 1 | Level read back from the SCL wire |
| sda_in | input | 1 | Level read back from the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle pulse when the START is complete |
| recovered | output | 1 | Recovery pulses were needed in the last sequence |
| fault | output | 1 | Last sequence aborted: SDA or SCL stuck low |

## Verification
A wrong internal state shows at the wires within one phase of `HALF_CNT` cycles. A wrong pulse counter shows up as a different number of SCL falls with SDA held low, or as a fault after the wrong pulse. A wrong branch after a sample shows up as a missing or extra STOP, or as a START formed while the target still holds SDA. An edge ordered wrongly, with SDA moving in the same cycle in which SCL is pulled low, is visible in that very cycle. A stale status flag is visible one cycle after the next request is accepted.

// File: rtl/i2csr_pkg.sv
package i2csr_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,     // bus released, waiting
    PH_HOLD,     // start done, both lines held low
    PH_PREP,     // SDA released, SCL unchanged
    PH_SCLHI,    // SCL released, sample at end
    PH_RECLO,    // recovery pulse low phase
    PH_STPLO,    // stop: SCL low, SDA released
    PH_STPSDA,   // stop: SCL low, SDA low
    PH_STPHI,    // stop: SCL released, SDA low
    PH_STPREL,   // stop: SDA released while SCL high
    PH_STASDA,   // start: SDA low while SCL high
    PH_STASCL    // start: SCL pulled low
  } phase_e;
endpackage

// File: rtl/i2csr_sync.sv
module i2csr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d[b]};
      end
      assign q[b] = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2csr_tick.sv
module i2csr_tick #(
  parameter int HALF_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_start_recover.sv
module i2c_start_recover #(
  parameter int HALF_CNT   = 8,
  parameter int MAX_PULSES = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic done,
  output logic recovered,
  output logic fault
);
  import i2csr_pkg::*;

  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PULSES);

  // reset release: assert asynchronously, release synchronously
  logic [1:0] rst_sh_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  i2csr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d({scl_in, sda_in}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  phase_e        ph_q, ph_d;
  logic [PW-1:0] pls_q, pls_d;
  logic          keep_q, keep_d;
  logic          done_q, done_d;
  logic          rec_q, rec_d;
  logic          flt_q, flt_d;
  logic          scl_q, scl_d;
  logic          sda_q, sda_d;
  logic          run, tick;

  assign run = (ph_q != PH_IDLE) && (ph_q != PH_HOLD);

  i2csr_tick #(.HALF_CNT(HALF_CNT)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick(tick)
  );

  always_comb begin
    ph_d   = ph_q;
    pls_d  = pls_q;
    keep_d = keep_q;
    done_d = 1'b0;
    rec_d  = rec_q;
    flt_d  = flt_q;
    case (ph_q)
      PH_IDLE, PH_HOLD: begin
        if (start_req) begin
          ph_d   = PH_PREP;
          pls_d  = '0;
          rec_d  = 1'b0;
          flt_d  = 1'b0;
          keep_d = (ph_q == PH_HOLD);
        end
      end
      PH_PREP:   if (tick) ph_d = PH_SCLHI;
      PH_SCLHI: begin
        if (tick) begin
          if (!scl_s) begin
            flt_d = 1'b1;
            ph_d  = PH_IDLE;
          end else if (sda_s) begin
            ph_d = (pls_q == '0) ? PH_STASDA : PH_STPLO;
          end else if (pls_q == PMAX) begin
            flt_d = 1'b1;
            ph_d  = PH_IDLE;
          end else begin
            ph_d  = PH_RECLO;
            pls_d = pls_q + 1'b1;
            rec_d = 1'b1;
          end
        end
      end
      PH_RECLO:  if (tick) ph_d = PH_SCLHI;
      PH_STPLO:  if (tick) ph_d = PH_STPSDA;
      PH_STPSDA: if (tick) ph_d = PH_STPHI;
      PH_STPHI: begin
        if (tick) begin
          if (!scl_s) begin
            flt_d = 1'b1;
            ph_d  = PH_IDLE;
          end else begin
            ph_d = PH_STPREL;
          end
        end
      end
      PH_STPREL: if (tick) ph_d = PH_STASDA;
      PH_STASDA: if (tick) ph_d = PH_STASCL;
      PH_STASCL: begin
        if (tick) begin
          ph_d   = PH_HOLD;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // registered line enables, decoded from the next phase
  always_comb begin
    case (ph_d)
      PH_HOLD, PH_RECLO, PH_STPLO, PH_STPSDA, PH_STASCL: scl_d = 1'b1;
      PH_PREP: scl_d = keep_d;
      default: scl_d = 1'b0;
    endcase
    case (ph_d)
      PH_HOLD, PH_STPSDA, PH_STPHI, PH_STASDA, PH_STASCL: sda_d = 1'b1;
      default: sda_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ph_q   <= PH_IDLE;
      pls_q  <= '0;
      keep_q <= 1'b0;
      done_q <= 1'b0;
      rec_q  <= 1'b0;
      flt_q  <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pls_q  <= pls_d;
      keep_q <= keep_d;
      done_q <= done_d;
      rec_q  <= rec_d;
      flt_q  <= flt_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
    end
  end

  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
  assign done      = done_q;
  assign recovered = rec_q;
  assign fault     = flt_q;
endmodule

// File: rtl/i2csr_chk.sv
module i2csr_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic fault
);
  logic       scl_prev_q;
  logic [4:0] fall_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b0;
      fall_cnt_q <= '0;
    end else begin
      scl_prev_q <= scl_oe;
      if (done || fault)
        fall_cnt_q <= '0;
      else if (scl_oe && !scl_prev_q && !sda_oe && fall_cnt_q != 5'd31)
        fall_cnt_q <= fall_cnt_q + 1'b1;
    end
  end

  // R6
  sda_still_at_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $stable(sda_oe));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_bus_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_oe && sda_oe));
  // R4
  fault_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!scl_oe && !sda_oe && !done));
  // R3
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt_q <= 5'(MAX_PULSES + 1));
endmodule

bind i2c_start_recover i2csr_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done(done), .fault(fault)
);

// File: tb/test_i2c_start_recover.sv
module test_i2c_start_recover;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic scl_oe, sda_oe, done, recovered, fault;
  logic scl_in, sda_in;

  // bus model state
  logic scl_stuck = 1'b0;
  logic tgt_hold = 1'b0;
  int   k_cfg = 0;
  int   falls = 0, pulses = 0, starts = 0, stops = 0, dones = 0;
  int   hp_cnt = 0, hp_meas = -1;
  logic hp_run = 1'b0;
  logic p_scl_oe = 1'b0, p_scl = 1'b1, p_sda = 1'b1;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  assign scl_in = !(scl_oe || scl_stuck);
  assign sda_in = !(sda_oe || tgt_hold);

  i2c_start_recover #(.HALF_CNT(HALF)) i_i2c_start_recover (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .recovered(recovered), .fault(fault)
  );

  // stimulus/expectation table: k, scl_stuck, pulses, recovered, fault, stop
  localparam int NV = 7;
  localparam logic [11:0] VEC [NV] = '{
    {4'd0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    {4'd1,  1'b0, 4'd1, 1'b1, 1'b0, 1'b1},
    {4'd3,  1'b0, 4'd3, 1'b1, 1'b0, 1'b1},
    {4'd9,  1'b0, 4'd9, 1'b1, 1'b0, 1'b1},
    {4'd10, 1'b0, 4'd9, 1'b1, 1'b1, 1'b0},
    {4'd0,  1'b1, 4'd0, 1'b0, 1'b1, 1'b0},
    {4'd0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0}
  };

  // bus monitor and target model, acts at the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (done) dones++;
    if (p_scl && scl_in && p_sda && !sda_in) begin
      starts++;
      hp_run = 1'b1;
      hp_cnt = 0;
    end else if (hp_run) begin
      hp_cnt++;
    end
    if (p_scl && scl_in && !p_sda && sda_in) stops++;
    if (scl_oe && !p_scl_oe) begin
      if (hp_run) begin
        hp_meas = hp_cnt;
        hp_run  = 1'b0;
      end
      if (!sda_oe && tgt_hold) pulses++;
      falls++;
      if (tgt_hold && falls >= k_cfg) tgt_hold = 1'b0;
    end
    p_scl_oe = scl_oe;
    p_scl    = scl_in;
    p_sda    = sda_in;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm(input int k, input logic stuck);
    @(posedge clk); #2;
    k_cfg = k; scl_stuck = stuck; tgt_hold = (k > 0);
    falls = 0; pulses = 0; starts = 0; stops = 0; dones = 0; hp_meas = -1;
  endtask

  task automatic pulse_start();
    @(posedge clk); #2; start_req = 1'b1;
    @(posedge clk); #2; start_req = 1'b0;
  endtask

  task automatic wait_end(output bit seen_done);
    seen_done = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk); #1;
      if (done) begin seen_done = 1'b1; break; end
      if (fault) break;
    end
  endtask

  initial begin : watchdog
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    bit got;
    logic [11:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 enables", {scl_oe, sda_oe}, 0);
    chk(!done && !fault && !recovered, "R1 status", {done, fault, recovered}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      arm(int'(v[11:8]), v[7]);
      pulse_start();
      @(negedge clk); #1;
      chk(!recovered && !fault, "R9 status cleared on request", {recovered, fault}, 0);
      wait_end(got);
      // R2/R3/R11 pulse count, R4/R5 fault
      chk(pulses == int'(v[6:3]), "R3 recovery pulses", pulses, int'(v[6:3]));
      chk(fault == v[1], "R4/R5 fault", fault, v[1]);
      chk(got == !v[1], "R8 done reached", got, !v[1]);
      chk(recovered == v[2], "R9 recovered", recovered, v[2]);
      chk(stops == int'(v[0]), "R7 stop before start", stops, v[0]);
      chk(starts == (v[1] ? 0 : 1), "R2 start formed", starts, v[1] ? 0 : 1);
      if (got) begin
        chk(scl_oe && sda_oe, "R8 bus low at done", {scl_oe, sda_oe}, 3);
        chk(hp_meas == HALF, "R8 start half period", hp_meas, HALF);
        @(negedge clk); #1;
        chk(!done, "R8 done single cycle", done, 0);
      end else begin
        chk(!scl_oe && !sda_oe, "R4 lines released on fault", {scl_oe, sda_oe}, 0);
      end
    end

    // R10: repeated request during a sequence is ignored
    arm(2, 1'b0);
    pulse_start();
    repeat (3 * HALF) @(posedge clk);
    #2 start_req = 1'b1;
    @(posedge clk); #2 start_req = 1'b0;
    wait_end(got);
    repeat (40 * HALF) @(negedge clk);
    chk(starts == 1, "R10 one start", starts, 1);
    chk(dones == 1, "R10 one done", dones, 1);
    chk(pulses == 2, "R11 shared low recovers", pulses, 2);

    // R1 reset mid-sequence releases the bus
    arm(5, 1'b0);
    pulse_start();
    repeat (4 * HALF) @(posedge clk);
    #2 rst_n = 1'b0;
    @(negedge clk); #1;
    chk(!scl_oe && !sda_oe && !recovered, "R1 reset mid-run", {scl_oe, sda_oe, recovered}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule